// File: doc/BRIEF.md
# Instruction Execute Datapath

This unit is the arithmetic and address stage of a small 16-bit processor. It takes a latched instruction word, two register operand values and the incremented program counter (`npc_in`). It produces two results. The first is a data result: an ALU value for write-back, an effective memory address, or a link value. The second is a target address that the fetch stage uses when a branch is taken. The unit splits the instruction word into its immediate and offset fields and extends each one to the datapath width. It then runs two paths in parallel. An ALU does add, AND and invert. A separate address adder adds one selected offset field to one selected base: `npc_in`, the base register, or zero.

`src_a` carries the value of the register named by instruction bits [8:6], which holds the first source or the base register. `src_b` carries the register named by bits [2:0]. The register file, the branch condition test and the memory access are not part of this unit. When `en` is high, the results are captured in output registers on the rising clock edge. A parameter can instead select a purely combinational variant of the unit.

Top module: `insn_exec_unit`

## Requirements
- R1: Opcode `0001` (add): the data result is `src_a` plus the second operand, truncated to 16 bits. The second operand is selected by bit [5]: when bit [5] is 0 it is `src_b`, and when bit [5] is 1 it is bits [4:0] sign-extended.
- R2: Opcode `0101` (and): the data result is `src_a` bitwise AND the second operand, which is selected by bit [5] exactly as in R1.
- R3: Opcode `1001` (invert): the data result is the bitwise complement of `src_a`, and bits [5:0] have no effect.
- R4: Opcodes `0000`, `0010`, `1010`, `1110`, `0011` and `1011`: the target address is `npc_in` plus bits [8:0] sign-extended. The data result equals the target address.
- R5: Opcodes `0110` and `0111`: the target address is `src_a` plus bits [5:0] sign-extended. The data result equals the target address.
- R6: Opcode `1100` gives a target address and data result equal to `src_a`. For opcode `0100`, when bit [11] is 1 the target address is `npc_in` plus bits [10:0] sign-extended; when bit [11] is 0 the target address is `src_a`. In both cases of opcode `0100` the data result is `npc_in`, the link value.
- R7: For opcodes `0001`, `0101` and `1001`, the target address equals `npc_in`.
- R8: Opcode `1111` gives a target address and data result equal to bits [7:0] zero-extended. Opcodes `1000` and `1101` give a data result of 0 and a target address equal to `npc_in`.
- R9: `alu_cy` is the carry out of the 16-bit add for opcode `0001`, and is 0 for every other opcode.
- R10: All outputs take their new values on the rising edge at which `en` is high. With `en` low, they hold their values whatever the other inputs do.
- R11: With `rst` high at a rising edge, all outputs become 0, regardless of `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Capture enable for the outputs |
| instr | input | 16 | Latched instruction word |
| npc_in | input | 16 | Incremented program counter |
| src_a | input | 16 | Operand from register at bits [8:6] (first source or base) |
| src_b | input | 16 | Operand from register at bits [2:0] |
| alu_res | output | 16 | Data result: ALU value, effective address or link value |
| alu_cy | output | 1 | Carry out of the add |
| tgt_addr | output | 16 | Target address for the fetch stage |

## Verification
Every one of the 65,536 instruction words is applied with fresh operands. A quarter of them use all-ones and one as operands, so that carries ripple the full width and negative offsets wrap. A wrong sign extension would show up as a target address off by a multiple of the field's span. A mis-decoded call word would send its jump through the wrong base, and a carry taken from a non-add opcode would set `alu_cy` where it must be 0. The bench also tests the hold behaviour by changing every input while `en` is low. It checks that reset wins over an asserted `en`. A faulty enable or reset path would let the outputs drift in these tests.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

   localparam int INSN_W = 16;
   localparam int OPC_W  = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_BRANCH  = 4'b0000,
      OPC_ADD     = 4'b0001,
      OPC_LOAD    = 4'b0010,
      OPC_STORE   = 4'b0011,
      OPC_CALL    = 4'b0100,
      OPC_AND     = 4'b0101,
      OPC_LOADB   = 4'b0110,
      OPC_STOREB  = 4'b0111,
      OPC_RSV_A   = 4'b1000,
      OPC_INV     = 4'b1001,
      OPC_LOADI   = 4'b1010,
      OPC_STOREI  = 4'b1011,
      OPC_JUMP    = 4'b1100,
      OPC_RSV_B   = 4'b1101,
      OPC_ADDRGEN = 4'b1110,
      OPC_VECTOR  = 4'b1111
   } opc_e;

   typedef enum logic [2:0] {
      FN_ADD  = 3'd0,
      FN_AND  = 3'd1,
      FN_INV  = 3'd2,
      FN_ADDR = 3'd3,
      FN_LINK = 3'd4,
      FN_ZERO = 3'd5
   } alu_fn_e;

   // offset select positions (one-hot)
   localparam int OFS_N    = 5;
   localparam int OFS_NONE = 0;
   localparam int OFS_F6   = 1;
   localparam int OFS_F9   = 2;
   localparam int OFS_F11  = 3;
   localparam int OFS_V8   = 4;

   // base select positions (one-hot)
   localparam int BASE_N    = 3;
   localparam int BASE_NPC  = 0;
   localparam int BASE_REG  = 1;
   localparam int BASE_NULL = 2;

   typedef struct packed {
      alu_fn_e           fn;
      logic              use_imm;
      logic [OFS_N-1:0]  ofs_sel;
      logic [BASE_N-1:0] base_sel;
   } ctrl_t;

   function automatic logic [OFS_N-1:0] ofs_pick(input int idx);
      logic [OFS_N-1:0] v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction

   function automatic logic [BASE_N-1:0] base_pick(input int idx);
      logic [BASE_N-1:0] v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
   import iexu_pkg::*;
(
   input  logic [INSN_W-1:0] instr,
   output ctrl_t             ctrl
);

   opc_e opc;
   assign opc = opc_e'(instr[INSN_W-1 -: OPC_W]);

   always_comb begin
      ctrl.fn       = FN_ZERO;
      ctrl.use_imm  = 1'b0;
      ctrl.ofs_sel  = ofs_pick(OFS_NONE);
      ctrl.base_sel = base_pick(BASE_NPC);
      unique case (opc)
         OPC_ADD: begin
            ctrl.fn      = FN_ADD;
            ctrl.use_imm = instr[5];
         end
         OPC_AND: begin
            ctrl.fn      = FN_AND;
            ctrl.use_imm = instr[5];
         end
         OPC_INV: begin
            ctrl.fn = FN_INV;
         end
         OPC_BRANCH, OPC_LOAD, OPC_LOADI, OPC_ADDRGEN, OPC_STORE, OPC_STOREI: begin
            ctrl.fn      = FN_ADDR;
            ctrl.ofs_sel = ofs_pick(OFS_F9);
         end
         OPC_LOADB, OPC_STOREB: begin
            ctrl.fn       = FN_ADDR;
            ctrl.ofs_sel  = ofs_pick(OFS_F6);
            ctrl.base_sel = base_pick(BASE_REG);
         end
         OPC_JUMP: begin
            ctrl.fn       = FN_ADDR;
            ctrl.base_sel = base_pick(BASE_REG);
         end
         OPC_CALL: begin
            ctrl.fn = FN_LINK;
            if (instr[11]) begin
               ctrl.ofs_sel = ofs_pick(OFS_F11);
            end else begin
               ctrl.base_sel = base_pick(BASE_REG);
            end
         end
         OPC_VECTOR: begin
            ctrl.fn       = FN_ADDR;
            ctrl.ofs_sel  = ofs_pick(OFS_V8);
            ctrl.base_sel = base_pick(BASE_NULL);
         end
         default: begin
            ctrl.fn = FN_ZERO;
         end
      endcase
   end

endmodule

// File: rtl/iexu_ext.sv
module iexu_ext #(
   parameter int IN_W   = 5,
   parameter int OUT_W  = 16,
   parameter bit SIGNED = 1'b1
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);

   localparam int PAD_W = OUT_W - IN_W;

   if (IN_W < 1 || PAD_W < 1) begin : g_bad_width
      $error("iexu_ext: output must be wider than a non-empty input");
   end

   if (SIGNED) begin : g_sign
      assign dout = {{PAD_W{din[IN_W-1]}}, din};
   end else begin : g_zero
      assign dout = {{PAD_W{1'b0}}, din};
   end

endmodule

// File: rtl/iexu_fields.sv
module iexu_fields
   import iexu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [INSN_W-1:0] instr,
   output logic [DATA_W-1:0] imm5,
   output logic [DATA_W-1:0] off6,
   output logic [DATA_W-1:0] off9,
   output logic [DATA_W-1:0] off11,
   output logic [DATA_W-1:0] vec8
);

   localparam int IMM_W   = 5;
   localparam int OFF6_W  = 6;
   localparam int OFF9_W  = 9;
   localparam int OFF11_W = 11;
   localparam int VEC_W   = 8;

   iexu_ext #(.IN_W(IMM_W),   .OUT_W(DATA_W), .SIGNED(1'b1)) u_imm5
      (.din(instr[IMM_W-1:0]),   .dout(imm5));
   iexu_ext #(.IN_W(OFF6_W),  .OUT_W(DATA_W), .SIGNED(1'b1)) u_off6
      (.din(instr[OFF6_W-1:0]),  .dout(off6));
   iexu_ext #(.IN_W(OFF9_W),  .OUT_W(DATA_W), .SIGNED(1'b1)) u_off9
      (.din(instr[OFF9_W-1:0]),  .dout(off9));
   iexu_ext #(.IN_W(OFF11_W), .OUT_W(DATA_W), .SIGNED(1'b1)) u_off11
      (.din(instr[OFF11_W-1:0]), .dout(off11));
   iexu_ext #(.IN_W(VEC_W),   .OUT_W(DATA_W), .SIGNED(1'b0)) u_vec8
      (.din(instr[VEC_W-1:0]),   .dout(vec8));

endmodule

// File: rtl/iexu_agen.sv
module iexu_agen
   import iexu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [OFS_N-1:0][DATA_W-1:0]  ofs_vec,
   input  logic [OFS_N-1:0]              ofs_sel,
   input  logic [BASE_N-1:0][DATA_W-1:0] base_vec,
   input  logic [BASE_N-1:0]             base_sel,
   output logic [DATA_W-1:0]             addr
);

   logic [OFS_N-1:0][DATA_W-1:0]  ofs_term;
   logic [BASE_N-1:0][DATA_W-1:0] base_term;
   logic [DATA_W-1:0]             ofs_mux;
   logic [DATA_W-1:0]             base_mux;

   for (genvar g = 0; g < OFS_N; g++) begin : g_ofs
      assign ofs_term[g] = ofs_vec[g] & {DATA_W{ofs_sel[g]}};
   end

   for (genvar g = 0; g < BASE_N; g++) begin : g_base
      assign base_term[g] = base_vec[g] & {DATA_W{base_sel[g]}};
   end

   always_comb begin
      ofs_mux = '0;
      for (int i = 0; i < OFS_N; i++) begin
         ofs_mux = ofs_mux | ofs_term[i];
      end
   end

   always_comb begin
      base_mux = '0;
      for (int i = 0; i < BASE_N; i++) begin
         base_mux = base_mux | base_term[i];
      end
   end

   assign addr = ofs_mux + base_mux;

   // the AND-OR muxes above are only correct with exactly one leg picked
   always_comb begin
      if (!$isunknown(ofs_sel)) begin
         assert_ofs_sel_onehot_R4: assert ($onehot(ofs_sel));
      end
      if (!$isunknown(base_sel)) begin
         assert_base_sel_onehot_R6: assert ($onehot(base_sel));
      end
   end

endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
   import iexu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] imm,
   input  logic              use_imm,
   input  alu_fn_e           fn,
   input  logic [DATA_W-1:0] addr,
   input  logic [DATA_W-1:0] link,
   output logic [DATA_W-1:0] res,
   output logic              cy
);

   localparam int SUM_W = DATA_W + 1;

   logic [DATA_W-1:0] opnd2;
   logic [SUM_W-1:0]  sum;

   assign opnd2 = use_imm ? imm : src_b;
   assign sum   = {1'b0, src_a} + {1'b0, opnd2};

   always_comb begin
      res = '0;
      cy  = 1'b0;
      unique case (fn)
         FN_ADD: begin
            res = sum[DATA_W-1:0];
            cy  = sum[DATA_W];
         end
         FN_AND:  res = src_a & opnd2;
         FN_INV:  res = ~src_a;
         FN_ADDR: res = addr;
         FN_LINK: res = link;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/insn_exec_unit.sv
module insn_exec_unit
   import iexu_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [15:0]       instr,
   input  logic [DATA_W-1:0] npc_in,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic [DATA_W-1:0] alu_res,
   output logic              alu_cy,
   output logic [DATA_W-1:0] tgt_addr
);

   if (DATA_W < INSN_W) begin : g_bad_width
      $error("insn_exec_unit: DATA_W must be at least the instruction width");
   end

   ctrl_t             ctrl;
   logic [DATA_W-1:0] imm5, off6, off9, off11, vec8;
   logic [DATA_W-1:0] nx_addr, nx_res;
   logic              nx_cy;

   logic [OFS_N-1:0][DATA_W-1:0]  ofs_vec;
   logic [BASE_N-1:0][DATA_W-1:0] base_vec;

   iexu_decode u_dec (
      .instr (instr),
      .ctrl  (ctrl)
   );

   iexu_fields #(.DATA_W(DATA_W)) u_fld (
      .instr (instr),
      .imm5  (imm5),
      .off6  (off6),
      .off9  (off9),
      .off11 (off11),
      .vec8  (vec8)
   );

   always_comb begin
      ofs_vec[OFS_NONE]   = '0;
      ofs_vec[OFS_F6]     = off6;
      ofs_vec[OFS_F9]     = off9;
      ofs_vec[OFS_F11]    = off11;
      ofs_vec[OFS_V8]     = vec8;
      base_vec[BASE_NPC]  = npc_in;
      base_vec[BASE_REG]  = src_a;
      base_vec[BASE_NULL] = '0;
   end

   iexu_agen #(.DATA_W(DATA_W)) u_agen (
      .ofs_vec  (ofs_vec),
      .ofs_sel  (ctrl.ofs_sel),
      .base_vec (base_vec),
      .base_sel (ctrl.base_sel),
      .addr     (nx_addr)
   );

   iexu_alu #(.DATA_W(DATA_W)) u_alu (
      .src_a   (src_a),
      .src_b   (src_b),
      .imm     (imm5),
      .use_imm (ctrl.use_imm),
      .fn      (ctrl.fn),
      .addr    (nx_addr),
      .link    (npc_in),
      .res     (nx_res),
      .cy      (nx_cy)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            alu_res  <= '0;
            alu_cy   <= 1'b0;
            tgt_addr <= '0;
         end else if (en) begin
            alu_res  <= nx_res;
            alu_cy   <= nx_cy;
            tgt_addr <= nx_addr;
         end
      end

      assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
         !en |=> ($stable(alu_res) && $stable(alu_cy) && $stable(tgt_addr)));

      assert_inv_complements_R3: assert property (@(posedge clk) disable iff (rst)
         (en && instr[15:12] == 4'b1001) |=> (alu_res == ~$past(src_a)));

      assert_jump_uses_base_R6: assert property (@(posedge clk) disable iff (rst)
         (en && instr[15:12] == 4'b1100) |=> (tgt_addr == $past(src_a)));

      assert_alu_target_npc_R7: assert property (@(posedge clk) disable iff (rst)
         (en && (instr[15:12] == 4'b0001 || instr[15:12] == 4'b0101 ||
                 instr[15:12] == 4'b1001)) |=> (tgt_addr == $past(npc_in)));

      assert_carry_add_only_R9: assert property (@(posedge clk) disable iff (rst)
         (en && instr[15:12] != 4'b0001) |=> !alu_cy);

      assert_base_offset_R5: assert property (@(posedge clk) disable iff (rst)
         (en && instr[15:13] == 3'b011) |=>
         (tgt_addr == $past(src_a) +
            {{(DATA_W-6){$past(instr[5])}}, $past(instr[5:0])}));
   end else begin : g_comb
      assign alu_res  = nx_res;
      assign alu_cy   = nx_cy;
      assign tgt_addr = nx_addr;
   end

endmodule

// File: tb/tb_insn_exec_unit.sv
`timescale 1ns/1ps
module tb_insn_exec_unit;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic [15:0] instr  = '0;
   logic [15:0] npc_in = '0;
   logic [15:0] src_a  = '0;
   logic [15:0] src_b  = '0;
   logic [15:0] alu_res;
   logic        alu_cy;
   logic [15:0] tgt_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [31:0] rng = 32'h1234_5678;

   always #4 clk = ~clk;

   insn_exec_unit #(.DATA_W(16), .REG_OUT(1'b1)) dut (
      .clk (clk), .rst (rst), .en (en), .instr (instr), .npc_in (npc_in),
      .src_a (src_a), .src_b (src_b),
      .alu_res (alu_res), .alu_cy (alu_cy), .tgt_addr (tgt_addr)
   );

   function automatic logic [15:0] sx(input logic [15:0] v, input int n);
      logic [15:0] m;
      m = 16'hFFFF << n;
      return v[n-1] ? (v | m) : (v & ~m);
   endfunction

   task automatic model(input logic [15:0] ir, a, b, np,
                        output logic [15:0] er, et, output logic ec,
                        output string tag);
      logic [16:0] s;
      logic [15:0] o2;
      er = '0; et = np; ec = 1'b0; tag = "R7";
      o2 = ir[5] ? sx(ir, 5) : b;
      case (ir[15:12])
         4'h1: begin s = {1'b0, a} + {1'b0, o2}; er = s[15:0]; ec = s[16]; tag = "R1"; end
         4'h5: begin er = a & o2; tag = "R2"; end
         4'h9: begin er = ~a; tag = "R3"; end
         4'h0, 4'h2, 4'hA, 4'hE, 4'h3, 4'hB: begin et = np + sx(ir, 9); er = et; tag = "R4"; end
         4'h6, 4'h7: begin et = a + sx(ir, 6); er = et; tag = "R5"; end
         4'hC: begin et = a; er = a; tag = "R6"; end
         4'h4: begin et = ir[11] ? np + sx(ir, 11) : a; er = np; tag = "R6"; end
         4'hF: begin et = {8'h00, ir[7:0]}; er = et; tag = "R8"; end
         default: begin er = '0; et = np; tag = "R8"; end
      endcase
   endtask

   task automatic chk(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic next_rng();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      logic [15:0] er, et, hr, ht;
      logic        ec, hc;
      string       tag;
      bit          pend;
      pend = 1'b0;
      er = '0; et = '0; ec = 1'b0;

      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11", "alu_res after reset", alu_res, 16'h0000);
      chk("R11", "tgt_addr after reset", tgt_addr, 16'h0000);
      chk("R11", "alu_cy after reset", {15'b0, alu_cy}, 16'h0000);
      rst = 1'b0;

      // exhaustive instruction sweep, one word per cycle (R1..R9)
      for (int i = 0; i < 65536; i++) begin
         @(negedge clk);
         if (pend) begin
            chk(tag, "alu_res", alu_res, er);
            chk(tag, "tgt_addr", tgt_addr, et);
            chk("R9", "alu_cy", {15'b0, alu_cy}, {15'b0, ec});
         end
         next_rng();
         instr  = i[15:0];
         npc_in = rng[31:16];
         if (i[1:0] == 2'b11) begin
            src_a = 16'hFFFF;
            src_b = 16'h0001;
         end else begin
            src_a = rng[15:0];
            src_b = rng[23:8];
         end
         en = 1'b1;
         model(instr, src_a, src_b, npc_in, er, et, ec, tag);
         pend = 1'b1;
      end
      @(negedge clk);
      chk(tag, "alu_res", alu_res, er);
      chk(tag, "tgt_addr", tgt_addr, et);
      chk("R9", "alu_cy", {15'b0, alu_cy}, {15'b0, ec});

      // R10: capture an add with carry, then hold while inputs change
      instr = 16'h1042; src_a = 16'hFFFF; src_b = 16'h0003; npc_in = 16'h4000; en = 1'b1;
      model(instr, src_a, src_b, npc_in, hr, ht, hc, tag);
      @(negedge clk);
      chk("R10", "alu_res captured", alu_res, hr);
      en = 1'b0;
      instr = 16'h9FFF; src_a = 16'h1234; src_b = 16'h5678; npc_in = 16'hABCD;
      repeat (3) @(negedge clk);
      chk("R10", "alu_res held", alu_res, hr);
      chk("R10", "tgt_addr held", tgt_addr, ht);
      chk("R10", "alu_cy held", {15'b0, alu_cy}, {15'b0, hc});

      // R11: reset wins over enable
      en = 1'b1; rst = 1'b1;
      @(negedge clk);
      chk("R11", "alu_res under reset with en", alu_res, 16'h0000);
      chk("R11", "tgt_addr under reset with en", tgt_addr, 16'h0000);
      rst = 1'b0;
      model(instr, src_a, src_b, npc_in, er, et, ec, tag);
      @(negedge clk);
      chk("R3", "alu_res after reset release", alu_res, er);
      en = 1'b0;
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

endmodule